// File: doc/BRIEF.md
# SPI Master Chip-Select Pulse Generator

This block produces the active-low slave-select line of an SPI master, together with the enable that lets the line be driven onto the pin. The select output is only driven when three conditions hold together: the interface is enabled, it is in master mode, and select-output driving is switched on. When driving is off, the internal select level still follows the transfer, but the pin is left free so that several masters can share the bus.

The shift engine tells the block when a frame has finished. It also reports whether another frame is already waiting. The block then decides the select level for the next clock periods, and raises a hold signal that keeps the shift engine from starting a frame.

A transfer begins with half an SPI clock period of select-low setup. When gap insertion is on, the block puts a deasserted gap of one full SPI clock period between frames that follow each other directly. Gap insertion is ignored when the clock phase is 1 or when the TI frame format is chosen. Every transfer ends with the line high as soon as the last frame is done and nothing more is pending.

Timing is counted in system clocks. `HALF_DIV` sets how many system clocks make up half an SPI clock period.

Top module: `spi_cs_pulse_gen`

## Requirements
- R1: `ss_oe` is 1 exactly when `en`, `master` and `ss_out_en` are all 1. It responds combinationally to these inputs.
- R2: Out of reset, and in the clock after `en` or `master` goes low, `ss_n` is 1 and `frame_hold` is 1.
- R3: From idle with `next_pending` high, `ss_n` goes to 0 in the next clock. `frame_hold` then stays 1 for exactly `HALF_DIV` clocks with `ss_n` at 0, and after that falls to 0.
- R4: Gap insertion applies when `pulse_en`=1, `cpha`=0 and `ti_fmt`=0. In that case, a `frame_done` during a frame with `next_pending`=1 drives `ss_n` to 1 for exactly 2*`HALF_DIV` clocks, starting in the next clock. `frame_hold` is 1 throughout the gap. When the gap ends, `ss_n` and `frame_hold` both return to 0 in the same clock.
- R5: A `frame_done` with `next_pending`=0 returns `ss_n` and `frame_hold` to 1 in the next clock, in every mode.
- R6: With `cpha`=1, gap insertion is ignored: a `frame_done` with `next_pending`=1 leaves `ss_n` and `frame_hold` at 0.
- R7: With `ti_fmt`=1, gap insertion is ignored in the same way as in R6.
- R8: With `pulse_en`=0, `ss_n` stays 0 across consecutive frames for as long as `next_pending` is 1 at each `frame_done`.
- R9: The `ss_n` level sequence does not depend on `ss_out_en`. With `ss_out_en`=0 the same low and high phases occur, while `ss_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable |
| master | input | 1 | Master mode |
| ss_out_en | input | 1 | Allow the select line to be driven onto the pin |
| pulse_en | input | 1 | Gap insertion between consecutive frames |
| cpha | input | 1 | Clock phase setting |
| ti_fmt | input | 1 | TI frame format selected |
| frame_done | input | 1 | One-clock strobe from the shift engine at the end of a frame |
| next_pending | input | 1 | Another frame is ready to be sent |
| ss_n | output | 1 | Active-low select level |
| ss_oe | output | 1 | Output enable for the select pin |
| frame_hold | output | 1 | High while the shift engine must not clock a frame |

## Verification
The bench sweeps all sixteen combinations of gap enable, clock phase, frame format and output enable. For each combination it measures the setup length and the gap length in clocks, and compares them with values it computes from `HALF_DIV`.

Each sweep step catches a specific fault:
- A design that lets the clock phase or the TI setting slip past its suppression would show a gap where none should appear.
- A gap counter that is off by one would give 2*`HALF_DIV`±1 clocks.
- A design that re-inserts setup after the gap would keep `frame_hold` high while `ss_n` is already low.

The bench also checks two exits. A lone final frame must raise the line at once. Dropping master mode in the middle of a frame must release both outputs. A design that waited for a frame boundary at either point would be caught holding the line low.

// File: rtl/csp_pkg.sv
package csp_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_SETUP = 2'd1,
        CS_XFER  = 2'd2,
        CS_GAP   = 2'd3
    } cs_state_e;

    typedef struct packed {
        logic active;    // enabled and in master mode
        logic drive;     // pin may be driven
        logic pulse_ok;  // gap insertion really applies
    } cs_mode_t;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic select_low(input cs_state_e s);
        return (s == CS_SETUP) || (s == CS_XFER);
    endfunction

endpackage

// File: rtl/csp_mode_decode.sv
module csp_mode_decode
    import csp_pkg::*;
(
    input  logic     en,
    input  logic     master,
    input  logic     ss_out_en,
    input  logic     pulse_en,
    input  logic     cpha,
    input  logic     ti_fmt,
    output cs_mode_t mode
);
    always_comb begin
        mode.active   = en & master;
        mode.drive    = en & master & ss_out_en;
        mode.pulse_ok = en & master & pulse_en & ~cpha & ~ti_fmt;
    end
endmodule

// File: rtl/csp_timer.sv
module csp_timer #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;
    logic         run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            lim_q <= limit;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == lim_q - 1'b1) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expired = run_q && (cnt_q == lim_q - 1'b1);

    // R3 / R4: a running window never counts past its length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < lim_q));
endmodule

// File: rtl/csp_fsm.sv
module csp_fsm
    import csp_pkg::*;
#(
    parameter int unsigned W         = 3,
    parameter int unsigned SETUP_LEN = 2,
    parameter int unsigned GAP_LEN   = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  cs_mode_t     mode,
    input  logic         frame_done,
    input  logic         next_pending,
    input  logic         timer_expired,
    output cs_state_e    state,
    output logic         timer_start,
    output logic [W-1:0] timer_limit
);
    localparam logic [W-1:0] SETUP_L = W'(SETUP_LEN);
    localparam logic [W-1:0] GAP_L   = W'(GAP_LEN);

    cs_state_e state_q;
    cs_state_e state_d;

    always_comb begin
        state_d     = state_q;
        timer_start = 1'b0;
        timer_limit = SETUP_L;
        if (!mode.active) begin
            state_d = CS_IDLE;
        end else begin
            unique case (state_q)
                CS_IDLE: if (next_pending) begin
                    state_d     = CS_SETUP;
                    timer_start = 1'b1;
                    timer_limit = SETUP_L;
                end
                CS_SETUP: if (timer_expired) state_d = CS_XFER;
                CS_XFER: if (frame_done) begin
                    if (!next_pending) begin
                        state_d = CS_IDLE;
                    end else if (mode.pulse_ok) begin
                        state_d     = CS_GAP;
                        timer_start = 1'b1;
                        timer_limit = GAP_L;
                    end
                end
                CS_GAP: if (timer_expired) state_d = CS_XFER;
                default: state_d = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CS_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    p_gap_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_XFER && frame_done && next_pending && mode.pulse_ok)
        |=> (state_q == CS_GAP));

    // R6 / R7 / R8: without gap insertion the frame stream continues
    p_no_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_XFER && frame_done && next_pending && mode.active && !mode.pulse_ok)
        |=> (state_q == CS_XFER));

    p_lone_end_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_XFER && frame_done && !next_pending)
        |=> (state_q == CS_IDLE));

    p_xfer_entry_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == CS_XFER) |-> ($past(state_q) == CS_SETUP || $past(state_q) == CS_GAP));
endmodule

// File: rtl/spi_cs_pulse_gen.sv
module spi_cs_pulse_gen
    import csp_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic master,
    input  logic ss_out_en,
    input  logic pulse_en,
    input  logic cpha,
    input  logic ti_fmt,
    input  logic frame_done,
    input  logic next_pending,
    output logic ss_n,
    output logic ss_oe,
    output logic frame_hold
);
    localparam int unsigned GAP_LEN = 2 * HALF_DIV;
    localparam int unsigned CNT_W   = cnt_bits(GAP_LEN);

    cs_mode_t           mode;
    cs_state_e          state;
    logic               t_start;
    logic               t_exp;
    logic [CNT_W-1:0]   t_limit;

    csp_mode_decode u_mode (
        .en(en), .master(master), .ss_out_en(ss_out_en),
        .pulse_en(pulse_en), .cpha(cpha), .ti_fmt(ti_fmt), .mode(mode)
    );

    csp_fsm #(.W(CNT_W), .SETUP_LEN(HALF_DIV), .GAP_LEN(GAP_LEN)) u_fsm (
        .clk(clk), .rst(rst), .mode(mode), .frame_done(frame_done),
        .next_pending(next_pending), .timer_expired(t_exp),
        .state(state), .timer_start(t_start), .timer_limit(t_limit)
    );

    csp_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .start(t_start), .limit(t_limit), .expired(t_exp)
    );

    assign ss_n       = ~select_low(state);
    assign ss_oe      = mode.drive;
    assign frame_hold = (state != CS_XFER);

    p_off_release_r2: assert property (@(posedge clk) disable iff (rst)
        !(en && master) |=> (ss_n && frame_hold));

    // R1: the pin is never driven outside enabled master operation
    p_oe_gate_r1: assert property (@(posedge clk) disable iff (rst)
        ss_oe |-> (master && en));
endmodule

// File: tb/spi_cs_pulse_gen_test.sv
module spi_cs_pulse_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, master = 0, ss_out_en = 0, pulse_en = 0, cpha = 0, ti_fmt = 0;
    logic frame_done = 0, next_pending = 0;
    logic ss_n, ss_oe, frame_hold;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cs_pulse_gen #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst(rst), .en(en), .master(master), .ss_out_en(ss_out_en),
        .pulse_en(pulse_en), .cpha(cpha), .ti_fmt(ti_fmt), .frame_done(frame_done),
        .next_pending(next_pending), .ss_n(ss_n), .ss_oe(ss_oe), .frame_hold(frame_hold)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_cfg(input int c);
        bit pe, cp, ti, soe, gap;
        int n;
        pe  = c[0]; cp = c[1]; ti = c[2]; soe = c[3];
        gap = pe && !cp && !ti;
        @(negedge clk);
        rst = 1; en = 0; master = 0; frame_done = 0; next_pending = 0;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ss_n && frame_hold, "R2 idle after reset", {ss_n, frame_hold}, 3);
        en = 1; master = 1; ss_out_en = soe; pulse_en = pe; cpha = cp; ti_fmt = ti;
        next_pending = 1;
        #1;
        chk(ss_oe == soe, "R1 oe follows enable", ss_oe, soe);
        // setup phase
        n = 0;
        @(negedge clk);
        while (frame_hold && !ss_n && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk(n == HALF, soe ? "R3 setup length" : "R9 setup length undriven", n, HALF);
        chk(!ss_n && !frame_hold, "R3 frame running", {ss_n, frame_hold}, 0);
        // back-to-back frame
        frame_done = 1; next_pending = 1;
        @(negedge clk);
        frame_done = 0;
        n = 0;
        while (ss_n && n < 20) begin
            chk(frame_hold, "R4 hold during gap", frame_hold, 1);
            n++;
            @(negedge clk);
        end
        if (gap)       chk(n == 2*HALF, "R4 gap length", n, 2*HALF);
        else if (!pe)  chk(n == 0, "R8 no gap when off", n, 0);
        else if (cp)   chk(n == 0, "R6 gap ignored with cpha", n, 0);
        else           chk(n == 0, "R7 gap ignored with ti", n, 0);
        chk(!frame_hold, "R4 next frame starts with low select", frame_hold, 0);
        // lone final frame
        frame_done = 1; next_pending = 0;
        @(negedge clk);
        frame_done = 0;
        chk(ss_n && frame_hold, "R5 line high after last frame", {ss_n, frame_hold}, 3);
        @(negedge clk);
        chk(ss_n, "R5 line stays high", ss_n, 1);
        // drop master mid frame
        next_pending = 1;
        repeat (HALF + 2) @(negedge clk);
        chk(!ss_n, "R3 restart low", ss_n, 0);
        master = 0;
        #1;
        chk(!ss_oe, "R1 oe off without master", ss_oe, 0);
        @(negedge clk);
        chk(ss_n && frame_hold, "R2 release on master drop", {ss_n, frame_hold}, 3);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 8; m++) begin
            en = m[0]; master = m[1]; ss_out_en = m[2];
            #1;
            chk(ss_oe == (m == 7), "R1 oe gating", ss_oe, (m == 7));
            @(negedge clk);
        end
        for (int c = 0; c < 16; c++) run_cfg(c);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule